// File: doc/BRIEF.md
# Priority-Mapped System Interrupt Controller

This block collects a set of peripheral interrupt lines and steers each one onto one of seven core priority levels, numbered 7 through 13. Every line carries a 4-bit level code held in a bank of assignment words. A line is *active* when its captured status bit and its enable (mask) bit are both set. For each level, the block raises a request toward the core while at least one active line is routed to that level.

When the core services a level, it pulses a service strobe with the level code. One cycle later the block reports which line wins. The winner is the lowest-numbered active line routed to that level. If no active line is routed there, the block flags the event as spurious and advances a spurious counter.

A wakeup-enable bank selects which lines may raise a wakeup request. Software reaches the status, mask, wakeup and assignment words over a simple word-addressed read/write bus. Writes land on the next clock edge, and reads are combinational.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all level requests and `wake_req` are 0 and `spur_count` is 0. Mask and wakeup words read 0. Every assignment word reads 0xFFFFFFFF, so no line is routed.
- R2: Line n takes its level code from bits [4*(n mod 8)+3 : 4*(n mod 8)] of the assignment word at bus address 6 + n/8.
- R3: A level code k in 0..6 routes the line to core level 7+k, which appears as bit k of `lvl_req`.
- R4: Level codes 7 to 15 route the line to no level, so the line never raises any bit of `lvl_req`.
- R5: A line is active only when its status bit and its mask bit are both 1. Line n sits at bit n mod 32 of bank n/32. Mask banks are at bus addresses 2 and 3.
- R6: When `svc_req` is high at a clock edge, `svc_done` is high for exactly the following cycle. In that cycle `svc_src` is the lowest-numbered active line whose code equals `svc_level`, and `svc_spurious` is 0.
- R7: If no active line carries the serviced level code, including the case where `svc_level` is 7, then `svc_spurious` is 1, `svc_src` is 0, and `spur_count` rises by one in the `svc_done` cycle. Otherwise `spur_count` holds.
- R8: Status banks at bus addresses 0 and 1 copy `irq_in` one clock after it changes. Bus writes to them have no effect.
- R9: Wakeup banks at bus addresses 4 and 5 are read/write. `wake_req` is high while any line has both its status bit and its wakeup bit set.
- R10: Mask, wakeup and assignment words read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 64 | Peripheral interrupt lines, level sensitive |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| lvl_req | output | 7 | Request per core level, bit k = level 7+k |
| wake_req | output | 1 | Wakeup request |
| svc_req | input | 1 | Service strobe |
| svc_level | input | 3 | Level code being serviced |
| svc_done | output | 1 | Service result valid |
| svc_src | output | 6 | Winning line index |
| svc_spurious | output | 1 | No active line at the serviced level |
| spur_count | output | 16 | Spurious event count |

## Verification
The assertions treat `svc_req` as a strobe whose result is judged against the requests visible in the same cycle. The properties therefore assume that the mask, the assignment words and the status are not written in the cycle the strobe is sampled. The bench honours this. It changes `irq_in` and performs bus writes only in cycles without a service strobe, and it lets one clock pass after each `irq_in` change before servicing. The spurious counter is kept far below its wrap point, so the increment property never sees a rollover.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    parameter int BANK_W = 32;
    parameter int CODE_W = 4;
    parameter int FIELDS_PER_WORD = BANK_W / CODE_W;
endpackage

// File: rtl/prio_irq_route.sv
module prio_irq_route #(
    parameter int NUM_LINES = 64,
    parameter int LEVELS    = 7,
    parameter int CODE_W    = 4
) (
    input  logic [NUM_LINES*CODE_W-1:0]     codes,
    input  logic [NUM_LINES-1:0]            active,
    output logic [LEVELS-1:0][NUM_LINES-1:0] lvl_vec,
    output logic [LEVELS-1:0]               lvl_req
);
    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
            assign lvl_vec[k][n] = active[n] &&
                (codes[n*CODE_W +: CODE_W] == CODE_W'(k));
        end
        assign lvl_req[k] = |lvl_vec[k];
    end
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int  NUM_LINES = 64,
    parameter int  LEVELS    = 7,
    parameter int  CNT_W     = 16,
    localparam int NB        = NUM_LINES / BANK_W,
    localparam int NA        = NUM_LINES / FIELDS_PER_WORD,
    localparam int ADDR_W    = $clog2(3 * NB + NA),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int LVL_W     = $clog2(LEVELS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BANK_W-1:0]    bus_wdata,
    output logic [BANK_W-1:0]    bus_rdata,
    output logic [LEVELS-1:0]    lvl_req,
    output logic                 wake_req,
    input  logic                 svc_req,
    input  logic [LVL_W-1:0]     svc_level,
    output logic                 svc_done,
    output logic [IDX_W-1:0]     svc_src,
    output logic                 svc_spurious,
    output logic [CNT_W-1:0]     spur_count
);
    localparam int STAT_BASE = 0;
    localparam int MASK_BASE = NB;
    localparam int WAKE_BASE = 2 * NB;
    localparam int ASGN_BASE = 3 * NB;

    typedef struct packed {
        logic [NB-1:0][BANK_W-1:0] status;
        logic [NB-1:0][BANK_W-1:0] mask;
        logic [NB-1:0][BANK_W-1:0] wake;
        logic [NA-1:0][BANK_W-1:0] asgn;
        logic                      done;
        logic                      spur;
        logic [IDX_W-1:0]          src;
        logic [CNT_W-1:0]          spur_cnt;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_LINES-1:0]              active;
    logic [LEVELS-1:0][NUM_LINES-1:0]  lvl_vec;
    logic [NUM_LINES-1:0]              sel_vec;
    logic                              pick_found;
    logic [IDX_W-1:0]                  pick_idx;

    assign active = s_q.status & s_q.mask;

    prio_irq_route #(.NUM_LINES(NUM_LINES), .LEVELS(LEVELS), .CODE_W(CODE_W)) u_route (
        .codes   (s_q.asgn),
        .active  (active),
        .lvl_vec (lvl_vec),
        .lvl_req (lvl_req)
    );

    always_comb begin
        sel_vec = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (svc_level == LVL_W'(k)) sel_vec = lvl_vec[k];
        end
    end

    prio_irq_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick (
        .vec   (sel_vec),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        s_d        = s_q;
        s_d.status = irq_in;
        s_d.done   = svc_req;
        s_d.spur   = 1'b0;
        s_d.src    = '0;
        if (svc_req) begin
            s_d.spur = !pick_found;
            s_d.src  = pick_found ? pick_idx : '0;
            if (!pick_found) s_d.spur_cnt = s_q.spur_cnt + 1'b1;
        end
        if (bus_we) begin
            for (int b = 0; b < NB; b++) begin
                if (bus_addr == ADDR_W'(MASK_BASE + b)) s_d.mask[b] = bus_wdata;
                if (bus_addr == ADDR_W'(WAKE_BASE + b)) s_d.wake[b] = bus_wdata;
            end
            for (int a = 0; a < NA; a++) begin
                if (bus_addr == ADDR_W'(ASGN_BASE + a)) s_d.asgn[a] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.asgn <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (bus_addr == ADDR_W'(STAT_BASE + b)) bus_rdata = s_q.status[b];
            if (bus_addr == ADDR_W'(MASK_BASE + b)) bus_rdata = s_q.mask[b];
            if (bus_addr == ADDR_W'(WAKE_BASE + b)) bus_rdata = s_q.wake[b];
        end
        for (int a = 0; a < NA; a++) begin
            if (bus_addr == ADDR_W'(ASGN_BASE + a)) bus_rdata = s_q.asgn[a];
        end
    end

    assign wake_req     = |(s_q.status & s_q.wake);
    assign svc_done     = s_q.done;
    assign svc_src      = s_q.src;
    assign svc_spurious = s_q.spur;
    assign spur_count   = s_q.spur_cnt;
endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker #(
    parameter int LEVELS = 7,
    parameter int LVL_W  = 3,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              svc_req,
    input logic [LVL_W-1:0]  svc_level,
    input logic              svc_done,
    input logic [IDX_W-1:0]  svc_src,
    input logic              svc_spurious,
    input logic [CNT_W-1:0]  spur_count,
    input logic [LEVELS-1:0] lvl_req
);
    logic lvl_hit;
    always_comb begin
        lvl_hit = 1'b0;
        for (int k = 0; k < LEVELS; k++) begin
            if (svc_level == LVL_W'(k)) lvl_hit = lvl_req[k];
        end
    end

    assert_done_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |=> svc_done);
    assert_no_done_without_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_req |=> !svc_done);
    assert_hit_not_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && lvl_hit) |=> !svc_spurious);
    assert_miss_is_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !lvl_hit) |=> svc_spurious);
    assert_spur_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && svc_spurious) |-> spur_count == $past(spur_count) + 1'b1);
    assert_spur_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(svc_done && svc_spurious) |-> $stable(spur_count));
    assert_spur_src_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && svc_spurious) |-> svc_src == '0);
endmodule

bind prio_irq_ctrl prio_irq_checker #(
    .LEVELS(LEVELS), .LVL_W(LVL_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  lvl_req;
    logic        wake_req;
    logic        svc_req = 1'b0;
    logic [2:0]  svc_level = '0;
    logic        svc_done;
    logic [5:0]  svc_src;
    logic        svc_spurious;
    logic [15:0] spur_count;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    typedef struct {
        logic [5:0]  src;
        logic        spur;
        logic [15:0] cnt;
        string       req;
    } exp_t;
    exp_t sb[$];
    logic [15:0] exp_cnt = '0;

    always #10 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic service(string req, logic [2:0] lvl, logic [5:0] src, logic spur);
        exp_t e;
        if (spur) exp_cnt = exp_cnt + 1'b1;
        e.src = spur ? 6'd0 : src; e.spur = spur; e.cnt = exp_cnt; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        svc_req = 1'b1; svc_level = lvl;
        @(negedge clk);
        svc_req = 1'b0;
        @(negedge clk);
    endtask

    // monitor: compares service results as they appear
    always @(negedge clk) begin
        if (rst_n && svc_done) begin
            if (sb.size() == 0) begin
                chk("R6 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.req, " src"}, 32'(svc_src), 32'(e.src));
                chk({e.req, " spurious"}, 32'(svc_spurious), 32'(e.spur));
                chk({e.req, " count"}, 32'(spur_count), 32'(e.cnt));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 chk("R1 lvl_req", 32'(lvl_req), 0);
        chk("R1 spur_count", 32'(spur_count), 0);
        chk("R1 wake_req", 32'(wake_req), 0);
        rd_chk("R1 mask", 4'd2, 32'h0);
        rd_chk("R1 wake", 4'd5, 32'h0);
        rd_chk("R1 assign", 4'd6, 32'hFFFF_FFFF);
        rd_chk("R1 assign", 4'd13, 32'hFFFF_FFFF);

        // lines 3, 5, 40 raised
        @(negedge clk);
        irq_in = (64'd1 << 3) | (64'd1 << 5) | (64'd1 << 40);
        @(negedge clk);
        rd_chk("R8 status0", 4'd0, 32'h28);
        rd_chk("R8 status1", 4'd1, 32'h100);
        wr(4'd0, 32'h0);
        rd_chk("R8 status write ignored", 4'd0, 32'h28);

        // R5: unmasked lines, still no routing
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd3, 32'hFFFF_FFFF);
        rd_chk("R10 mask readback", 4'd3, 32'hFFFF_FFFF);
        #1 chk("R4 all codes 15", 32'(lvl_req), 0);
        service("R7 nothing routed", 3'd0, 6'd0, 1'b1);

        // R2/R3: lines 3 and 5 to code 2 (level 9)
        wr(4'd6, 32'hFF2F_2FFF);
        rd_chk("R10 assign readback", 4'd6, 32'hFF2F_2FFF);
        #1 chk("R3 code 2 -> bit 2", 32'(lvl_req), 32'h04);
        service("R6 lowest wins", 3'd2, 6'd3, 1'b0);

        // R5: mask off line 3 -> line 5 wins
        wr(4'd2, 32'hFFFF_FFF7);
        service("R5 masked line skipped", 3'd2, 6'd5, 1'b0);

        // R2: line 40 field 0 of word 11, code 6
        wr(4'd11, 32'hFFFF_FFF6);
        #1 chk("R2 line 40 code 6", 32'(lvl_req), 32'h44);
        service("R2 line 40 level 13", 3'd6, 6'd40, 1'b0);
        service("R7 empty level", 3'd4, 6'd0, 1'b1);

        // R4: code 7 routes nowhere
        wr(4'd11, 32'hFFFF_FFF7);
        #1 chk("R4 code 7 no level", 32'(lvl_req), 32'h04);
        service("R7 level code 7", 3'd7, 6'd0, 1'b1);

        // R8: status tracks input drop
        @(negedge clk);
        irq_in = 64'd1 << 40;
        @(negedge clk);
        #1 chk("R8 status follows input", 32'(lvl_req), 0);
        service("R7 line dropped", 3'd2, 6'd0, 1'b1);

        // R9: wakeup
        #1 chk("R9 wake off", 32'(wake_req), 0);
        wr(4'd5, 32'h100);
        rd_chk("R9 wake readback", 4'd5, 32'h100);
        #1 chk("R9 wake on", 32'(wake_req), 1);
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd5, 32'h0);
        #1 chk("R9 wake bank1 cleared", 32'(wake_req), 0);

        // R5: mask all off
        @(negedge clk);
        irq_in = 64'd1 << 5;
        wr(4'd2, 32'h0);
        #1 chk("R5 masked -> no request", 32'(lvl_req), 0);

        repeat (3) @(negedge clk);
        chk("R6 scoreboard drained", 32'(sb.size()), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule